// File: doc/BRIEF.md
# Indirect Register File Host Port

This block is the control port of a video decoder. A host processor reaches twenty 8-bit command registers through a narrow strobed bus: chip select, read and write strobes, a register-select line and an 8-bit data bus split into input, output and output-enable. The host first loads an address register with the register-select line low. It then reads or writes the addressed command register with the line high. The address stays loaded, so repeated accesses to one register need no new address cycle.

Every bus input passes through a two-stage synchroniser on the system clock. A write commits on the release of the write strobe, and only when the strobe was low for at least two clock samples. Register 00h carries two self-clearing soft resets: one pulses the data-path reset, the other also restores every command register to its default. Register 13h holds the per-group high-impedance controls, and a global output-enable input overrides them. These are decoded into one registered drive-enable per output group for the pad ring.

Top module: `hp_host_port`

## Requirements
- R1: While `rst` is high at a clock edge, the command registers take their defaults (01h=02h, 06h=02h, 09h=80h, 11h=80h, all others 00h) and the address register clears to 00h. `host_dout_en`, `drive_en` and `dp_reset` are held at 0.
- R2: A qualified write with `host_sel` low loads the address register. A qualified read with `host_sel` low returns the address register.
- R3: A qualified write with `host_sel` high loads the command register named by the address register and leaves the address unchanged. A second access to the same register needs no address write.
- R4: A write uses chip select, select and data from the last clock sample in which `host_wr_n` was low. Its result is visible after the third rising edge, counting the first edge that samples `host_wr_n` high.
- R5: A write strobe low for only one clock sample changes nothing. A read strobe low for only one sample never raises `host_dout_en`.
- R6: `host_dout_en` is high after every edge at which the last two synchronised samples both show `host_cs_n` and `host_rd_n` low. While it is high, `host_dout` carries the selected value; otherwise `host_dout` is 00h. With a read of exactly two samples, the output enable is high for exactly one cycle.
- R7: Command writes while the address is 14h or above change no register. Command reads at such addresses return 00h.
- R8: A committed command write to 00h with bit 1 or bit 0 set raises `dp_reset` for exactly one cycle, starting at the commit edge. At the next edge, bits 1:0 of register 00h clear and bits 7:2 keep their written value.
- R9: When the committed value has bit 0 set, all command registers return to their R1 defaults at the edge after the commit. The address register is kept.
- R10: `drive_en[g]` is high exactly when the synchronised `out_en_n` is low and bit g of register 13h is 0, one clock after synchronisation. The bit order is 7 luma/chroma data, 6 blue data, 5 line sync, 4 field sync, 3 line blank, 2 field blank, 1 field parity, 0 lock status and chroma flag.
- R11: A write strobe whose last low sample shows `host_cs_n` high changes no register and not the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_wr_n | input | 1 | Write strobe, active low, commits on release |
| host_rd_n | input | 1 | Read strobe, active low |
| host_sel | input | 1 | 0 = address register, 1 = addressed command register |
| host_din | input | 8 | Write data from the host |
| host_dout | output | 8 | Read data to the host |
| host_dout_en | output | 1 | High while the bus pad should drive `host_dout` |
| out_en_n | input | 1 | Global output enable, active low |
| drive_en | output | 8 | Per-group pad drive enable, 1 = drive |
| dp_reset | output | 1 | One-cycle data-path reset pulse |
| cfg_image | output | 160 | Register contents, register n at bits 8n+7:8n |

## Verification
The embedded assertions watch several properties on every cycle. The data-path reset pulse must last one cycle, and the soft-reset bits must be clear afterwards. A full restore must yield the default image. Command writes must leave the address stable. Writes to an out-of-range address must leave the image untouched. The bus must be driven only after two qualifying read samples, and the drive enables must be zero after a synchronised global disable. The bench's scenarios are needed to show end-to-end behaviour from the pins: exact commit latency, rejection of one-sample strobes and deselected writes, read-back of the address and of registers with no new address write, the default values themselves, and the per-group bit order of the drive enables.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int BUS_W     = 8;
    localparam int SOFT_REG  = 0;
    localparam int DRIVE_REG = 19;
    localparam int SOFT_FULL = 0;
    localparam int SOFT_DP   = 1;

    typedef struct packed {
        logic             cs_n;
        logic             wr_n;
        logic             rd_n;
        logic             sel;
        logic             oe_n;
        logic [BUS_W-1:0] data;
    } pin_sample_t;

    localparam pin_sample_t IDLE_SAMPLE = '{
        cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, sel: 1'b0, oe_n: 1'b1, data: '0
    };

    function automatic logic [BUS_W-1:0] reg_default(input int idx);
        case (idx)
            1:       return 8'h02;
            6:       return 8'h02;
            9:       return 8'h80;
            17:      return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_cur,
    output logic [W-1:0] q_prev
);
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] chain [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
        end
    end

    assign q_cur  = chain[STAGES-1];
    assign q_prev = chain[STAGES];
endmodule

// File: rtl/hp_strobe.sv
module hp_strobe #(
    parameter int MIN_PULSE  = 2,
    parameter bit ON_RELEASE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic act_now,
    input  logic act_prev,
    output logic qual
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (act_now) begin
            if (run_cnt != CNT_W'(MIN_PULSE)) run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    generate
        if (ON_RELEASE) begin : g_release
            assign qual = !act_now && act_prev && (run_cnt >= CNT_W'(MIN_PULSE));
        end else begin : g_hold
            assign qual = act_now && (run_cnt >= CNT_W'(MIN_PULSE - 1));
            if (MIN_PULSE >= 2) begin : g_chk
                AST_HOLD_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (rst)
                    qual |-> act_prev); // R5
            end
        end
    endgenerate
endmodule

// File: rtl/hp_regbank.sv
module hp_regbank
    import hp_pkg::*;
#(
    parameter int NUM_REGS = 20
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [BUS_W-1:0]          idx,
    input  logic [BUS_W-1:0]          wr_data,
    output logic [BUS_W-1:0]          rd_data,
    output logic [NUM_REGS*BUS_W-1:0] image,
    output logic                      dp_reset
);
    localparam int IDX_W = $clog2(NUM_REGS);

    function automatic logic [NUM_REGS*BUS_W-1:0] def_image();
        logic [NUM_REGS*BUS_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_REGS; i++) v[i*BUS_W +: BUS_W] = reg_default(i);
        return v;
    endfunction

    localparam logic [NUM_REGS*BUS_W-1:0] DEF_IMAGE = def_image();

    logic [BUS_W-1:0] regs [NUM_REGS];
    logic             dp_q;
    logic             in_range;

    assign in_range = (idx < BUS_W'(NUM_REGS));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_default(i);
            dp_q <= 1'b0;
        end else begin
            dp_q <= 1'b0;
            if (dp_q) begin
                if (regs[SOFT_REG][SOFT_FULL]) begin
                    for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_default(i);
                end else begin
                    regs[SOFT_REG][SOFT_DP]   <= 1'b0;
                    regs[SOFT_REG][SOFT_FULL] <= 1'b0;
                end
            end
            if (wr_en && in_range) begin
                regs[idx[IDX_W-1:0]] <= wr_data;
                if (idx == BUS_W'(SOFT_REG))
                    dp_q <= wr_data[SOFT_DP] | wr_data[SOFT_FULL];
            end
        end
    end

    assign rd_data  = in_range ? regs[idx[IDX_W-1:0]] : '0;
    assign dp_reset = dp_q;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_image
            assign image[g*BUS_W +: BUS_W] = regs[g];
        end
    endgenerate

    AST_DP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        dp_q |=> !dp_q); // R8
    AST_SOFT_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        dp_q |=> (regs[SOFT_REG][1:0] == 2'b00)); // R8
    AST_FULL_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (dp_q && regs[SOFT_REG][SOFT_FULL]) |=> (image == DEF_IMAGE)); // R9
    AST_HIGH_ADDR_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_range && !dp_q) |=> $stable(image)); // R7
endmodule

// File: rtl/hp_drive_ctl.sv
module hp_drive_ctl #(
    parameter int GROUPS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              oe_n_s,
    input  logic [GROUPS-1:0] hiz_mask,
    output logic [GROUPS-1:0] drive_en
);
    always_ff @(posedge clk) begin
        if (rst)         drive_en <= '0;
        else if (oe_n_s) drive_en <= '0;
        else             drive_en <= ~hiz_mask;
    end
endmodule

// File: rtl/hp_host_port.sv
module hp_host_port
    import hp_pkg::*;
#(
    parameter int NUM_REGS  = 20,
    parameter int MIN_PULSE = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      host_cs_n,
    input  logic                      host_wr_n,
    input  logic                      host_rd_n,
    input  logic                      host_sel,
    input  logic [7:0]                host_din,
    output logic [7:0]                host_dout,
    output logic                      host_dout_en,
    input  logic                      out_en_n,
    output logic [7:0]                drive_en,
    output logic                      dp_reset,
    output logic [NUM_REGS*8-1:0]     cfg_image
);
    localparam int SMP_W = $bits(pin_sample_t);

    pin_sample_t      raw, s_cur, s_prev;
    logic [SMP_W-1:0] cur_vec, prev_vec;
    logic             wr_fire, rd_fire, commit;
    logic [BUS_W-1:0] addr_q, cmd_rd;

    assign raw = '{cs_n: host_cs_n, wr_n: host_wr_n, rd_n: host_rd_n,
                   sel: host_sel, oe_n: out_en_n, data: host_din};

    hp_sync #(.W(SMP_W), .STAGES(2), .RST_VAL(IDLE_SAMPLE)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d      (raw),
        .q_cur  (cur_vec),
        .q_prev (prev_vec)
    );

    assign s_cur  = pin_sample_t'(cur_vec);
    assign s_prev = pin_sample_t'(prev_vec);

    hp_strobe #(.MIN_PULSE(MIN_PULSE), .ON_RELEASE(1'b1)) u_wr_strobe (
        .clk      (clk),
        .rst      (rst),
        .act_now  (!s_cur.wr_n),
        .act_prev (!s_prev.wr_n),
        .qual     (wr_fire)
    );

    hp_strobe #(.MIN_PULSE(MIN_PULSE), .ON_RELEASE(1'b0)) u_rd_strobe (
        .clk      (clk),
        .rst      (rst),
        .act_now  (!s_cur.cs_n && !s_cur.rd_n),
        .act_prev (!s_prev.cs_n && !s_prev.rd_n),
        .qual     (rd_fire)
    );

    assign commit = wr_fire && !s_prev.cs_n;

    always_ff @(posedge clk) begin
        if (rst)                       addr_q <= '0;
        else if (commit && !s_prev.sel) addr_q <= s_prev.data;
    end

    hp_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (commit && s_prev.sel),
        .idx      (addr_q),
        .wr_data  (s_prev.data),
        .rd_data  (cmd_rd),
        .image    (cfg_image),
        .dp_reset (dp_reset)
    );

    hp_drive_ctl #(.GROUPS(8)) u_drive (
        .clk      (clk),
        .rst      (rst),
        .oe_n_s   (s_cur.oe_n),
        .hiz_mask (cfg_image[DRIVE_REG*8 +: 8]),
        .drive_en (drive_en)
    );

    assign host_dout_en = rd_fire;
    assign host_dout    = rd_fire ? (s_cur.sel ? cmd_rd : addr_q) : '0;

    AST_ADDR_KEPT_ON_CMD: assert property (@(posedge clk) disable iff (rst)
        (commit && s_prev.sel) |=> $stable(addr_q)); // R3
    AST_READ_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        host_dout_en |-> (!s_prev.rd_n && !s_prev.cs_n)); // R6
    AST_CS_GATES_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && s_prev.cs_n && !dp_reset) |=> ($stable(addr_q) && $stable(cfg_image))); // R11
    AST_HIZ_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
        s_prev.oe_n |-> (drive_en == 8'h00)); // R10
    AST_HIGH_ADDR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (host_dout_en && s_cur.sel && (addr_q >= 8'(NUM_REGS))) |-> (host_dout == 8'h00)); // R7
endmodule

// File: tb/hp_host_port_test.sv
`timescale 1ns/1ps
module hp_host_port_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, sel = 1'b0, oe_n = 1'b0;
    logic [7:0]   din = 8'h00;
    logic [7:0]   dout;
    logic         dout_en;
    logic [7:0]   drive_en;
    logic         dp_reset;
    logic [159:0] image;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 0;

    always #5 clk = ~clk;

    hp_host_port uut (
        .clk(clk), .rst(rst), .host_cs_n(cs_n), .host_wr_n(wr_n), .host_rd_n(rd_n),
        .host_sel(sel), .host_din(din), .host_dout(dout), .host_dout_en(dout_en),
        .out_en_n(oe_n), .drive_en(drive_en), .dp_reset(dp_reset), .cfg_image(image)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input int i);
        if (i == 1 || i == 6) return 8'h02;
        if (i == 9 || i == 17) return 8'h80;
        return 8'h00;
    endfunction

    // behavioural reference model: history of pin samples, one per rising edge
    typedef struct { bit cs, wr, rd, sel, oe; bit [7:0] d; } smp_t;
    smp_t     hist[$];
    bit [7:0] m_regs [20];
    bit [7:0] m_addr;
    bit       m_dp;
    bit [7:0] m_drv;

    function automatic smp_t idle_smp();
        smp_t s;
        s.cs = 1; s.wr = 1; s.rd = 1; s.sel = 0; s.oe = 1; s.d = 0;
        return s;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 20; i++) m_regs[i] = dflt(i);
            m_addr = 0; m_dp = 0; m_drv = 0;
            hist = {};
            for (int i = 0; i < 6; i++) hist.push_back(idle_smp());
        end else begin
            int n;
            smp_t c2, c3, c4, now;
            bit   new_dp;
            n  = hist.size();
            c2 = hist[n-2]; c3 = hist[n-3]; c4 = hist[n-4];
            m_drv  = c2.oe ? 8'h00 : ~m_regs[19];
            new_dp = 0;
            if (m_dp) begin
                if (m_regs[0][0]) for (int i = 0; i < 20; i++) m_regs[i] = dflt(i);
                else m_regs[0][1:0] = 2'b00;
            end
            if (c2.wr && !c3.wr && !c4.wr && !c3.cs) begin
                if (!c3.sel) m_addr = c3.d;
                else if (m_addr < 20) begin
                    m_regs[m_addr] = c3.d;
                    if (m_addr == 0) new_dp = c3.d[1] | c3.d[0];
                end
            end
            m_dp = new_dp;
            now.cs = cs_n; now.wr = wr_n; now.rd = rd_n; now.sel = sel; now.oe = oe_n; now.d = din;
            hist.push_back(now);
            void'(hist.pop_front());
        end
    end

    // every-cycle comparison, away from the rising edge
    int oe_cnt = 0, dp_cnt = 0;
    logic [7:0] last_rd = 0;
    always @(negedge clk) begin
        if (dout_en) begin oe_cnt++; last_rd = dout; end
        if (dp_reset) dp_cnt++;
        if (cmp_en) begin
            int n;
            bit m_oe;
            bit [7:0] m_out, img_a, img_e;
            bit img_ok;
            n = hist.size();
            m_oe = !hist[n-2].cs && !hist[n-2].rd && !hist[n-3].cs && !hist[n-3].rd;
            m_out = !m_oe ? 8'h00 : (!hist[n-2].sel ? m_addr : (m_addr < 20 ? m_regs[m_addr] : 8'h00));
            img_ok = 1; img_a = 0; img_e = 0;
            for (int i = 0; i < 20; i++)
                if (img_ok && image[i*8 +: 8] !== m_regs[i]) begin
                    img_ok = 0; img_a = image[i*8 +: 8]; img_e = m_regs[i];
                end
            chk(img_ok, "R3 register image vs model", img_a, img_e);
            chk(dout_en === m_oe, "R6 read enable vs model", dout_en, m_oe);
            chk(dout === m_out, "R6 read data vs model", dout, m_out);
            chk(drive_en === m_drv, "R10 drive enables vs model", drive_en, m_drv);
            chk(dp_reset === m_dp, "R8 data-path pulse vs model", dp_reset, m_dp);
        end
    end

    task automatic bus_wr(input logic s, input logic [7:0] d, input int lowc, input logic cs);
        @(negedge clk); cs_n = cs; sel = s; din = d; wr_n = 0;
        repeat (lowc) @(negedge clk);
        wr_n = 1;
        @(negedge clk); cs_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_rd(input logic s, input int lowc, output logic [7:0] v, output int seen);
        @(negedge clk); oe_cnt = 0; cs_n = 0; sel = s; rd_n = 0;
        repeat (lowc) @(negedge clk);
        rd_n = 1; cs_n = 1;
        repeat (4) @(negedge clk);
        v = last_rd; seen = oe_cnt;
    endtask

    logic [7:0]   v;
    int           seen;
    logic [159:0] snap;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (2) @(posedge clk);
        cmp_en = 1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(dout_en === 0, "R1 read enable in reset", dout_en, 0);
        chk(drive_en === 0, "R1 drive enables in reset", drive_en, 0);
        chk(dp_reset === 0, "R1 pulse in reset", dp_reset, 0);
        chk(image[1*8 +: 8] === 8'h02 && image[9*8 +: 8] === 8'h80 && image[0 +: 8] === 8'h00,
            "R1 default bytes", image[79:0], 0);
        rst = 0;
        repeat (6) @(negedge clk);
        chk(drive_en === 8'hFF, "R10 all groups driven after reset", drive_en, 8'hFF);
        bus_wr(0, 8'h11, 3, 0); bus_rd(1, 4, v, seen);
        chk(v === 8'h80, "R1 default of 11h", v, 8'h80);
        bus_wr(0, 8'h06, 3, 0); bus_rd(1, 4, v, seen);
        chk(v === 8'h02, "R1 default of 06h", v, 8'h02);
        // R2 / R3
        bus_wr(0, 8'h05, 3, 0); bus_rd(0, 4, v, seen);
        chk(v === 8'h05, "R2 address read back", v, 8'h05);
        bus_wr(1, 8'h5A, 3, 0);
        bus_rd(1, 4, v, seen); chk(v === 8'h5A, "R3 command read", v, 8'h5A);
        bus_rd(1, 4, v, seen); chk(v === 8'h5A, "R3 repeat read without address write", v, 8'h5A);
        bus_rd(0, 4, v, seen); chk(v === 8'h05, "R3 address kept", v, 8'h05);
        // R5 short strobes
        bus_wr(1, 8'h11, 1, 0);
        chk(image[5*8 +: 8] === 8'h5A, "R5 one-sample write ignored", image[5*8 +: 8], 8'h5A);
        bus_rd(1, 1, v, seen); chk(seen == 0, "R5 one-sample read not driven", seen, 0);
        // R6 minimum read
        bus_rd(1, 2, v, seen);
        chk(seen == 1, "R6 two-sample read drives one cycle", seen, 1);
        chk(v === 8'h5A, "R6 two-sample read data", v, 8'h5A);
        // R11 deselected write
        bus_wr(1, 8'h77, 3, 1);
        chk(image[5*8 +: 8] === 8'h5A, "R11 write with chip select high", image[5*8 +: 8], 8'h5A);
        // R4 commit latency
        bus_wr(0, 8'h07, 3, 0);
        @(negedge clk); cs_n = 0; sel = 1; din = 8'h33; wr_n = 0;
        repeat (3) @(negedge clk);
        wr_n = 1;
        @(posedge clk); @(posedge clk); #1;
        chk(image[7*8 +: 8] === 8'h00, "R4 not visible after second edge", image[7*8 +: 8], 8'h00);
        @(posedge clk); #1;
        chk(image[7*8 +: 8] === 8'h33, "R4 visible after third edge", image[7*8 +: 8], 8'h33);
        @(negedge clk); cs_n = 1; repeat (3) @(negedge clk);
        // R7 out-of-range address
        bus_wr(0, 8'h14, 3, 0); snap = image;
        bus_wr(1, 8'hAA, 3, 0);
        chk(image === snap, "R7 write above 13h dropped", 0, 0);
        bus_rd(1, 4, v, seen); chk(v === 8'h00 && seen > 0, "R7 read above 13h is zero", v, 8'h00);
        bus_wr(0, 8'hFF, 3, 0); bus_rd(1, 4, v, seen);
        chk(v === 8'h00, "R7 read at FFh is zero", v, 8'h00);
        // R10 drive enable decode
        bus_wr(0, 8'h13, 3, 0); bus_wr(1, 8'hA5, 3, 0);
        chk(drive_en === 8'h5A, "R10 per-group masks", drive_en, 8'h5A);
        chk(drive_en[7] === 1'b0, "R10 bit 7 luma/chroma group off", drive_en[7], 0);
        @(negedge clk); oe_n = 1; repeat (4) @(negedge clk);
        chk(drive_en === 8'h00, "R10 global disable", drive_en, 0);
        oe_n = 0; repeat (4) @(negedge clk);
        chk(drive_en === 8'h5A, "R10 global enable restored", drive_en, 8'h5A);
        // R8 data-path reset only
        bus_wr(0, 8'h05, 3, 0); bus_wr(1, 8'h3C, 3, 0);
        bus_wr(0, 8'h00, 3, 0);
        dp_cnt = 0; bus_wr(1, 8'h06, 3, 0);
        chk(dp_cnt == 1, "R8 single pulse", dp_cnt, 1);
        bus_rd(1, 4, v, seen); chk(v === 8'h04, "R8 soft bits self-cleared", v, 8'h04);
        chk(image[5*8 +: 8] === 8'h3C, "R8 other registers kept", image[5*8 +: 8], 8'h3C);
        // R9 full restore
        dp_cnt = 0; bus_wr(1, 8'h01, 3, 0);
        chk(dp_cnt == 1, "R9 pulse on full restore", dp_cnt, 1);
        chk(image[5*8 +: 8] === 8'h00 && image[9*8 +: 8] === 8'h80 && image[19*8 +: 8] === 8'h00,
            "R9 defaults restored", image[5*8 +: 8], 8'h00);
        bus_rd(0, 4, v, seen); chk(v === 8'h00, "R9 address kept", v, 8'h00);
        chk(drive_en === 8'hFF, "R9 drive masks back to default", drive_en, 8'hFF);
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule